// File: doc/BRIEF.md
# Read-Leveling Window Selector

This block picks one read-delay setting for each byte lane of a memory interface. A training engine sweeps the read delay and records which settings passed. It then hands the block one pass/fail bitmap per lane: bit i stands for delay setting i, and 1 means that setting passed. For each lane the block walks the bitmap one bit per cycle and finds the longest unbroken run of passing settings. It then returns one setting inside that run.

There are two ways to pick the setting. In back-off mode the block takes the run's last setting and steps back by a programmed amount. If back-off mode is off, or the stepped-back setting is not usable, the block takes the run's midpoint. Once the ninth lane (lane 8) has been resolved, the block looks at the chosen delays of neighbouring lanes. It flags a set whose delays neither rise nor fall steadily across the lanes, and it flags any jump between neighbours that exceeds a programmed limit.

Top module: `rlvl_window_sel`

## Requirements
- R1: A lane is taken when `in_valid` and `in_ready` are both high at a rising clock edge. In `in_map`, bit i is delay setting i, and a 1 marks a pass. After a lane is taken, `in_ready` stays low until that lane's result has been issued.
- R2: The chosen window is the longest contiguous run of 1s in the bitmap. When two runs share the longest length, the run with the lower setting numbers wins.
- R3: Back-off selection applies when all of these hold: `cfg_off_en` is 1, `cfg_offset` is at most the run's last index E, and bitmap bit E−`cfg_offset` is 1. The result is then E−`cfg_offset`.
- R4: In every other case the result is S+(L−1)/2, rounded down, where S is the run's first index and L is its length. For an even L this rounds toward the smaller setting. This covers back-off mode off, an offset larger than E, and a target bit of 0.
- R5: A bitmap with no 1s gives `res_fail`=1 and `res_delay`=0. Otherwise `res_fail`=0.
- R6: Each result is issued as a one-cycle `res_valid` pulse. `res_lane` gives the lane number, which counts 0 to 8 in the order lanes were taken and returns to 0 after lane 8.
- R7: After lane 8's result, `done` pulses for one cycle. `trend_error` is then 1 if the nine delays, in lane order, are neither non-decreasing nor non-increasing. `cfg_trend_dis`=1 forces it to 0.
- R8: With the `done` pulse, `step_error` is 1 if any two neighbouring lanes' delays differ by more than `cfg_max_step`. A `cfg_max_step` of 0 forces it to 0.
- R9: After reset, `in_ready`=1, and `res_valid`, `done`, `trend_error` and `step_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Lane bitmap offered |
| in_ready | output | 1 | Block can take a lane |
| in_map | input | 64 | Pass/fail bitmap, bit i = setting i |
| cfg_off_en | input | 1 | Enable back-off selection |
| cfg_offset | input | 6 | Back-off distance from the run end |
| cfg_trend_dis | input | 1 | Disable the monotonic trend check |
| cfg_max_step | input | 6 | Largest allowed neighbour difference, 0 disables the check |
| res_valid | output | 1 | Result pulse |
| res_lane | output | 4 | Lane number of the result |
| res_delay | output | 6 | Chosen delay setting |
| res_fail | output | 1 | Lane had no passing setting |
| done | output | 1 | Cross-lane checks finished |
| trend_error | output | 1 | Delays are not monotonic |
| step_error | output | 1 | A neighbour difference is over the limit |

## Verification
Each lane's result appears at the ports about one bitmap length after the lane is taken, so errors in the run tracker show up quickly. A run-length or run-start register that drifts gives a wrong `res_delay` on the very next pulse. A tie rule that is broken gives a wrong result only on bitmaps that contain two equally long runs, which is why such bitmaps are among the stimuli. Errors in the lane counter or the stored delays show up through `res_lane` at once. They reach the two flags only at the `done` pulse, nine lanes later. The bench therefore uses sets that rise, sets that fall, sets that zigzag, and step limits placed exactly at and one below the largest neighbour difference.

// File: rtl/rlvl_pkg.sv
package rlvl_pkg;
  typedef enum logic [1:0] {SC_IDLE, SC_SCAN, SC_FIN} scan_st_t;
endpackage

// File: rtl/rlvl_scan.sv
module rlvl_scan #(
  parameter int NSET = 64,
  parameter int DW   = $clog2(NSET)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NSET-1:0] map,
  input  logic            off_en,
  input  logic [DW-1:0]   offset,
  output logic            busy,
  output logic            res_valid,
  output logic [DW-1:0]   res_delay,
  output logic            res_fail
);
  import rlvl_pkg::*;

  scan_st_t        st;
  logic [NSET-1:0] map_q;
  logic [DW-1:0]   idx, cur_start, best_start, nxt_start;
  logic [DW:0]     cur_len, best_len, nxt_len;
  logic            bit_now;
  logic [DW:0]     end_w, mid_w, tgt_w;
  logic            off_ok;

  assign bit_now = map_q[idx];
  assign busy    = (st != SC_IDLE);

  always_comb begin
    nxt_len   = bit_now ? cur_len + 1'b1 : '0;
    nxt_start = (bit_now && cur_len == '0) ? idx : cur_start;
    end_w     = {1'b0, best_start} + best_len - 1'b1;
    mid_w     = {1'b0, best_start} + ((best_len - 1'b1) >> 1);
    tgt_w     = end_w - {1'b0, offset};
    off_ok    = off_en && ({1'b0, offset} <= end_w) && map_q[tgt_w[DW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SC_IDLE;
      map_q      <= '0;
      idx        <= '0;
      cur_start  <= '0;
      cur_len    <= '0;
      best_start <= '0;
      best_len   <= '0;
      res_valid  <= 1'b0;
      res_delay  <= '0;
      res_fail   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        SC_IDLE: if (start) begin
          map_q     <= map;
          idx       <= '0;
          cur_len   <= '0;
          cur_start <= '0;
          best_len  <= '0;
          best_start<= '0;
          st        <= SC_SCAN;
        end
        SC_SCAN: begin
          cur_len   <= nxt_len;
          cur_start <= nxt_start;
          if (nxt_len > best_len) begin
            best_len   <= nxt_len;
            best_start <= nxt_start;
          end
          idx <= idx + 1'b1;
          if (idx == DW'(NSET - 1)) st <= SC_FIN;
        end
        SC_FIN: begin
          res_valid <= 1'b1;
          if (best_len == '0) begin
            res_fail  <= 1'b1;
            res_delay <= '0;
          end else begin
            res_fail  <= 1'b0;
            res_delay <= off_ok ? tgt_w[DW-1:0] : mid_w[DW-1:0];
          end
          st <= SC_IDLE;
        end
        default: st <= SC_IDLE;
      endcase
    end
  end

  // R5
  fail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fail) |-> (res_delay == '0));
  // R3
  pick_passes_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_fail) |-> map_q[res_delay]);
endmodule

// File: rtl/rlvl_trend.sv
module rlvl_trend #(
  parameter int NL = 9,
  parameter int DW = 6,
  parameter int LW = $clog2(NL)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [NL*DW-1:0] delays,
  input  logic           trend_dis,
  input  logic [DW-1:0]  max_step,
  output logic           busy,
  output logic           done,
  output logic           trend_error,
  output logic           step_error
);
  logic [LW-1:0] k;
  logic          inc_ok, dec_ok, step_bad;
  logic [DW-1:0] a, b, diff;
  logic          inc_n, dec_n, step_n;

  always_comb begin
    a      = delays[(k - 1'b1) * DW +: DW];
    b      = delays[k * DW +: DW];
    diff   = (b >= a) ? b - a : a - b;
    inc_n  = inc_ok & (b >= a);
    dec_n  = dec_ok & (b <= a);
    step_n = step_bad | ((max_step != '0) && (diff > max_step));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      k           <= '0;
      inc_ok      <= 1'b1;
      dec_ok      <= 1'b1;
      step_bad    <= 1'b0;
      trend_error <= 1'b0;
      step_error  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy     <= 1'b1;
          k        <= LW'(1);
          inc_ok   <= 1'b1;
          dec_ok   <= 1'b1;
          step_bad <= 1'b0;
        end
      end else begin
        inc_ok   <= inc_n;
        dec_ok   <= dec_n;
        step_bad <= step_n;
        k        <= k + 1'b1;
        if (k == LW'(NL - 1)) begin
          busy        <= 1'b0;
          done        <= 1'b1;
          trend_error <= !trend_dis && !(inc_n || dec_n);
          step_error  <= step_n;
        end
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  trend_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (done && trend_dis) |-> !trend_error);
  // R8
  step_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (done && max_step == '0) |-> !step_error);
endmodule

// File: rtl/rlvl_window_sel.sv
module rlvl_window_sel #(
  parameter int NSET = 64,
  parameter int NL   = 9,
  parameter int DW   = $clog2(NSET),
  parameter int LW   = $clog2(NL)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [NSET-1:0] in_map,
  input  logic            cfg_off_en,
  input  logic [DW-1:0]   cfg_offset,
  input  logic            cfg_trend_dis,
  input  logic [DW-1:0]   cfg_max_step,
  output logic            res_valid,
  output logic [LW-1:0]   res_lane,
  output logic [DW-1:0]   res_delay,
  output logic            res_fail,
  output logic            done,
  output logic            trend_error,
  output logic            step_error
);
  logic            scan_busy, trend_busy, start, go;
  logic [LW-1:0]   lane_cnt;
  logic [DW-1:0]   dly_q [NL];
  logic [NL*DW-1:0] dly_flat;

  assign go       = res_valid && (res_lane == LW'(NL - 1));
  assign in_ready = !scan_busy && !trend_busy && !go;
  assign start    = in_valid && in_ready;

  generate
    for (genvar g = 0; g < NL; g++) begin : g_pack
      assign dly_flat[g*DW +: DW] = dly_q[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_cnt <= '0;
      res_lane <= '0;
      for (int i = 0; i < NL; i++) dly_q[i] <= '0;
    end else begin
      if (start) begin
        res_lane <= lane_cnt;
        lane_cnt <= (lane_cnt == LW'(NL - 1)) ? '0 : lane_cnt + 1'b1;
      end
      if (res_valid) dly_q[res_lane] <= res_delay;
    end
  end

  rlvl_scan #(.NSET(NSET), .DW(DW)) u_scan (
    .clk(clk), .rst(rst), .start(start), .map(in_map),
    .off_en(cfg_off_en), .offset(cfg_offset), .busy(scan_busy),
    .res_valid(res_valid), .res_delay(res_delay), .res_fail(res_fail)
  );

  rlvl_trend #(.NL(NL), .DW(DW), .LW(LW)) u_trend (
    .clk(clk), .rst(rst), .go(go), .delays(dly_flat),
    .trend_dis(cfg_trend_dis), .max_step(cfg_max_step), .busy(trend_busy),
    .done(done), .trend_error(trend_error), .step_error(step_error)
  );

  // R1
  one_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  // R6
  lane_range_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_lane <= LW'(NL - 1)));
endmodule

// File: tb/rlvl_window_sel_test.sv
`timescale 1ns/1ps
module rlvl_window_sel_test;
  localparam int NSET = 64, NL = 9, DW = 6, LW = 4;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready;
  logic [NSET-1:0] in_map = '0;
  logic cfg_off_en = 0, cfg_trend_dis = 0;
  logic [DW-1:0] cfg_offset = '0, cfg_max_step = '0;
  logic res_valid, res_fail, done, trend_error, step_error;
  logic [LW-1:0] res_lane;
  logic [DW-1:0] res_delay;

  always #2.5 clk = ~clk;

  rlvl_window_sel uut (.*);

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [15:0] sb_q [$];
  int set_d [NL];
  int lane_tb = 0;
  logic [NSET-1:0] mp [NL];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [NSET-1:0] run(input int s, input int l);
    logic [NSET-1:0] m = '0;
    for (int i = s; i < s + l && i < NSET; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic void model(input logic [NSET-1:0] m, input bit oen,
                                input int off, output int d, output bit f);
    int cs = 0, cl = 0, bs = 0, bl = 0, e;
    for (int i = 0; i < NSET; i++) begin
      if (m[i]) begin
        if (cl == 0) cs = i;
        cl++;
        if (cl > bl) begin bl = cl; bs = cs; end
      end else cl = 0;
    end
    f = (bl == 0);
    if (f) begin d = 0; return; end
    e = bs + bl - 1;
    if (oen && off <= e && m[e - off]) d = e - off;
    else d = bs + (bl - 1) / 2;
  endfunction

  task automatic send_lane(input logic [NSET-1:0] m);
    int d; bit f;
    model(m, cfg_off_en, int'(cfg_offset), d, f);
    set_d[lane_tb] = d;
    sb_q.push_back({f, 3'b0, 4'(lane_tb), 2'b0, 6'(d)});
    lane_tb = (lane_tb == NL - 1) ? 0 : lane_tb + 1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_map = m;
    @(negedge clk);
    in_valid = 0;
  endtask

  // monitor / scoreboard: R2 R3 R4 R5 R6
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb_q.size() == 0) check(0, "R6", "unexpected result", 1, 0);
      else begin
        logic [15:0] e;
        e = sb_q.pop_front();
        check(res_delay == e[5:0], "R2/R3/R4", "res_delay", res_delay, e[5:0]);
        check(res_fail == e[15], "R5", "res_fail", res_fail, e[15]);
        check(res_lane == e[11:8], "R6", "res_lane", res_lane, e[11:8]);
      end
    end
  end

  task automatic run_set(input bit oen, input int off, input bit dis,
                         input int mx);
    bit inc = 1, dec = 1, stp = 0, te;
    int dd, to = 0;
    cfg_off_en = oen; cfg_offset = DW'(off);
    cfg_trend_dis = dis; cfg_max_step = DW'(mx);
    for (int i = 0; i < NL; i++) send_lane(mp[i]);
    for (int i = 1; i < NL; i++) begin
      if (set_d[i] < set_d[i-1]) inc = 0;
      if (set_d[i] > set_d[i-1]) dec = 0;
      dd = set_d[i] - set_d[i-1];
      if (dd < 0) dd = -dd;
      if (mx != 0 && dd > mx) stp = 1;
    end
    te = !dis && !(inc || dec);
    while (!done && to < 2000) begin @(negedge clk); to++; end
    check(done, "R7", "done pulse", done, 1);
    check(trend_error == te, "R7", "trend_error", trend_error, te);
    check(step_error == stp, "R8", "step_error", step_error, stp);
    @(negedge clk);
    check(!done, "R7", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R9 reset state
    check(in_ready == 1, "R9", "in_ready", in_ready, 1);
    check(res_valid == 0, "R9", "res_valid", res_valid, 0);
    check(done == 0, "R9", "done", done, 0);
    check(trend_error == 0 && step_error == 0, "R9", "flags",
          {trend_error, step_error}, 0);
    // R1 R2 R3 rising set with a tie lane
    for (int k = 0; k < NL; k++) mp[k] = run(4*k, 10);
    mp[3] = run(12, 6) | run(30, 6);
    run_set(1, 2, 0, 0);
    run_set(1, 2, 0, 8);   // R8 limit equals largest step
    run_set(1, 2, 0, 7);   // R8 one below
    // R4 R5 falling set, midpoint with odd/even lengths, empty last lane
    for (int k = 0; k < NL; k++) mp[k] = run(50 - 5*k, (k % 2) ? 4 : 5);
    mp[NL-1] = '0;
    run_set(0, 2, 0, 0);
    // R3 R4 zigzag: target miss, isolated target hit, full map, offset past end
    for (int k = 0; k < NL; k++)
      mp[k] = (k % 2) ? (run(20, 10) | run(17, 1)) : run(20, 10);
    mp[4] = '1;
    mp[5] = run(2, 4);
    run_set(1, 12, 0, 3);
    run_set(1, 12, 1, 0); // R7 R8 bypasses
    repeat (10) @(negedge clk);
    check(sb_q.size() == 0, "R6", "pending results", sb_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule